// File: doc/BRIEF.md
# Fixed-Level Internal Interrupt Controller

This block gathers interrupt requests from five on-chip peripherals (three timers and two DMA channels) and presents a single interrupt line to the CPU. Each peripheral is tied to a hard-wired priority level: timer 0 at level 0, DMA 0 at level 2, DMA 1 at level 3, timer 1 at level 4 and timer 2 at level 5. A lower level number means a higher priority. Per-level request, in-service and mask bits are kept in registers. A pending, unmasked request competes only if its level is below a programmable priority ceiling and below every level already in service.

The CPU reads and writes all state through a small word-addressed register bus. It takes an interrupt with a one-cycle acknowledge pulse, reads a vector that combines a programmable base with the winning level, and retires the interrupt by writing the level number to an end-of-interrupt register. Each source also has a control word. The mask bit in that word is the same storage as the source's bit in the shared mask register.

Top module: `fixed_level_intc`

## Requirements
- R1: A synchronous active-high reset clears every request and in-service bit, sets the mask bit of all five sources, loads the priority ceiling with 7 and clears the vector base.
- R2: The request, in-service and mask registers use bit n for level n: bit 0 timer 0, bit 2 DMA 0, bit 3 DMA 1, bit 4 timer 1, bit 5 timer 2. Bit 1 and bits 15:6 always read zero, whatever is written.
- R3: A one-cycle pulse on a peripheral's request input sets its request bit on the next clock edge, whether or not the source is masked.
- R4: `irq` is high exactly when some source has its request bit set, its mask bit clear, and a level lower than both the ceiling (address 3, bits 2:0) and the lowest level with its in-service bit set.
- R5: An `ack` pulse while `irq` is high clears the request bit and sets the in-service bit of the lowest eligible level, in one clock. An `ack` while `irq` is low changes nothing.
- R6: A read of address 0 returns the programmed base in bits 15:3 and the current winning level in bits 2:0 (zero when none). A write to address 0 stores bits 15:3.
- R7: A write to address 1 clears the in-service bit of the level given in bits 2:0. Codes 1, 6 and 7 change nothing. Address 1 reads zero.
- R8: A write to the request register (address 5) updates only bit 0. All other request bits ignore the write.
- R9: The in-service register (address 4) can be read and written.
- R10: Control words sit at addresses 8, 9, 10, 11 and 12 for levels 0, 2, 3, 4 and 5. Bit 3 is the source's mask bit, shared with the mask register (address 2), so a write through either view changes both. Bits 2:0 always read the source's fixed level and ignore writes.
- R11: Addresses 6, 7 and 13 to 15 read zero, and writes to them change no state.
- R12: In the same cycle, a peripheral pulse sets a request bit even when `ack` clears it. An `ack` sets an in-service bit even when an end-of-interrupt write for that level clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr0_irq | input | 1 | Timer 0 request pulse (level 0) |
| dma0_irq | input | 1 | DMA 0 request pulse (level 2) |
| dma1_irq | input | 1 | DMA 1 request pulse (level 3) |
| tmr1_irq | input | 1 | Timer 1 request pulse (level 4) |
| tmr2_irq | input | 1 | Timer 2 request pulse (level 5) |
| ack | input | 1 | CPU acknowledge pulse |
| addr | input | 4 | Register word address |
| wr | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
Two pairs of events can collide. An acknowledge can clear a request bit in the same cycle that the same peripheral pulses again. An acknowledge can set an in-service bit in the same cycle that an end-of-interrupt write names that level. The bench drives each pair in a single cycle after first arranging the state so that the acknowledged winner is exactly the level under contention. It then reads the request and in-service registers back and checks that the setting event won. A behavioural model applies writes first, then the acknowledge, then peripheral pulses, and it judges `irq` on every clock.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int DATA_W       = 16;
    localparam int ADDR_W       = 4;
    localparam int LVL_W        = 3;
    localparam int SLOT_N       = 6;
    localparam int CTL_BASE     = 8;
    localparam int CTL_MASK_BIT = 3;

    localparam logic [SLOT_N-1:0] SLOT_USED = 6'b111101;
    localparam logic [LVL_W-1:0]  PLM_RESET = '1;

    typedef logic [SLOT_N-1:0] slot_vec_t;

    typedef struct packed {
        logic             hit;
        logic [LVL_W-1:0] lvl;
    } pick_t;

    typedef enum logic [ADDR_W-1:0] {
        A_VEC  = 4'd0,
        A_EOI  = 4'd1,
        A_MASK = 4'd2,
        A_PLM  = 4'd3,
        A_ISR  = 4'd4,
        A_REQ  = 4'd5
    } reg_addr_e;

    // lowest set slot wins
    function automatic pick_t pick_lowest(slot_vec_t v);
        pick_t p;
        p.hit = 1'b0;
        p.lvl = '0;
        for (int i = SLOT_N - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.lvl = LVL_W'(i);
            end
        end
        return p;
    endfunction

    // bits at or below level l
    function automatic slot_vec_t upto_mask(logic [LVL_W-1:0] l);
        slot_vec_t m;
        for (int i = 0; i < SLOT_N; i++) m[i] = (i <= int'(l));
        return m;
    endfunction

    // k-th control word maps to the k-th used slot
    function automatic pick_t ctl_slot(logic [ADDR_W-1:0] a);
        pick_t p;
        int    idx;
        int    cnt;
        p.hit = 1'b0;
        p.lvl = '0;
        idx   = int'(a) - CTL_BASE;
        cnt   = 0;
        for (int i = 0; i < SLOT_N; i++) begin
            if (SLOT_USED[i]) begin
                if (cnt == idx) begin
                    p.hit = 1'b1;
                    p.lvl = LVL_W'(i);
                end
                cnt++;
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/icu_arbiter.sv
module icu_arbiter
    import icu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  slot_vec_t        req_q,
    input  slot_vec_t        isr_q,
    input  slot_vec_t        mask_q,
    input  logic [LVL_W-1:0] plm,
    output pick_t            win,
    output logic             irq
);

    pick_t            top_isr;
    logic [LVL_W-1:0] ceil_lvl;
    slot_vec_t        elig;

    always_comb begin
        top_isr  = pick_lowest(isr_q & SLOT_USED);
        ceil_lvl = plm;
        if (top_isr.hit && (top_isr.lvl < plm)) ceil_lvl = top_isr.lvl;
    end

    generate
        for (genvar g = 0; g < SLOT_N; g++) begin : g_elig
            assign elig[g] = SLOT_USED[g] & req_q[g] & ~mask_q[g]
                           & (LVL_W'(g) < ceil_lvl);
        end
    endgenerate

    assign win = pick_lowest(elig);
    assign irq = win.hit;

    // R4: winner sits below the ceiling
    a_r4_below_ceiling: assert property (@(posedge clk) disable iff (rst)
        irq |-> (win.lvl < plm));

    // R4: nothing at or above the winner's priority is in service
    a_r4_below_service: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((isr_q & upto_mask(win.lvl)) == '0));

    // R4: a masked or idle slot never wins
    a_r4_winner_pending: assert property (@(posedge clk) disable iff (rst)
        irq |-> (req_q[win.lvl] && !mask_q[win.lvl]));

endmodule

// File: rtl/icu_state.sv
module icu_state
    import icu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  slot_vec_t         src_set,
    input  logic              ack,
    input  pick_t             win,
    input  logic              wr_req,
    input  logic              wr_isr,
    input  logic              wr_mask,
    input  logic              wr_ctl,
    input  logic [LVL_W-1:0]  ctl_lvl,
    input  logic              wr_eoi,
    input  logic [SLOT_N-1:0] wbits,
    output slot_vec_t         req_q,
    output slot_vec_t         isr_q,
    output slot_vec_t         mask_q
);

    slot_vec_t        req_n, isr_n, mask_n;
    logic [LVL_W-1:0] eoi_lvl;

    assign eoi_lvl = wbits[LVL_W-1:0];

    // order: software writes, end-of-interrupt, acknowledge, peripheral pulses
    always_comb begin
        req_n  = req_q;
        isr_n  = isr_q;
        mask_n = mask_q;
        if (wr_req)  req_n[0] = wbits[0];
        if (wr_isr)  isr_n    = wbits;
        if (wr_mask) mask_n   = wbits;
        if (wr_ctl)  mask_n[ctl_lvl] = wbits[CTL_MASK_BIT];
        if (wr_eoi && (int'(eoi_lvl) < SLOT_N)) isr_n[eoi_lvl] = 1'b0;
        if (ack && win.hit) begin
            req_n[win.lvl] = 1'b0;
            isr_n[win.lvl] = 1'b1;
        end
        req_n  = (req_n | src_set) & SLOT_USED;
        isr_n  = isr_n  & SLOT_USED;
        mask_n = mask_n & SLOT_USED;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            isr_q  <= '0;
            mask_q <= SLOT_USED;
        end else begin
            req_q  <= req_n;
            isr_q  <= isr_n;
            mask_q <= mask_n;
        end
    end

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (req_q == '0 && isr_q == '0 && mask_q == SLOT_USED));

    // R5: acknowledged level enters service
    a_r5_ack_sets_service: assert property (@(posedge clk) disable iff (rst)
        (ack && win.hit) |=> isr_q[$past(win.lvl)]);

    // R5: acknowledged request drops unless re-raised
    a_r5_ack_clears_req: assert property (@(posedge clk) disable iff (rst)
        (ack && win.hit && !src_set[win.lvl]) |=> !req_q[$past(win.lvl)]);

    // R12: a peripheral pulse always lands
    a_r12_pulse_lands: assert property (@(posedge clk) disable iff (rst)
        (|src_set) |=> ((req_q & $past(src_set & SLOT_USED)) == $past(src_set & SLOT_USED)));

    // R10: control-word write reaches the shared mask bit
    a_r10_ctl_alias: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && !wr_mask) |=> (mask_q[$past(ctl_lvl)] == $past(wbits[CTL_MASK_BIT])));

endmodule

// File: rtl/icu_regs.sv
module icu_regs
    import icu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  slot_vec_t         req_q,
    input  slot_vec_t         isr_q,
    input  slot_vec_t         mask_q,
    input  pick_t             win,
    output logic [DATA_W-1:0] rdata,
    output logic [LVL_W-1:0]  plm,
    output logic              wr_req,
    output logic              wr_isr,
    output logic              wr_mask,
    output logic              wr_ctl,
    output logic [LVL_W-1:0]  ctl_lvl,
    output logic              wr_eoi
);

    pick_t                    cs;
    logic [DATA_W-1:LVL_W]    base_q;
    logic [LVL_W-1:0]         plm_q;

    assign cs      = ctl_slot(addr);
    assign wr_req  = wr && (addr == A_REQ);
    assign wr_isr  = wr && (addr == A_ISR);
    assign wr_mask = wr && (addr == A_MASK);
    assign wr_eoi  = wr && (addr == A_EOI);
    assign wr_ctl  = wr && cs.hit;
    assign ctl_lvl = cs.lvl;
    assign plm     = plm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            plm_q  <= PLM_RESET;
        end else begin
            if (wr && (addr == A_VEC)) base_q <= wdata[DATA_W-1:LVL_W];
            if (wr && (addr == A_PLM)) plm_q  <= wdata[LVL_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_VEC:   rdata = {base_q, (win.hit ? win.lvl : LVL_W'(0))};
            A_MASK:  rdata = DATA_W'(mask_q);
            A_PLM:   rdata = DATA_W'(plm_q);
            A_ISR:   rdata = DATA_W'(isr_q);
            A_REQ:   rdata = DATA_W'(req_q);
            default: if (cs.hit) rdata = DATA_W'({mask_q[cs.lvl], cs.lvl});
        endcase
    end

    // R11: holes in the map read zero
    a_r11_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == 4'd6 || addr == 4'd7 || addr > 4'd12) |-> (rdata == '0));

    // R6: vector low bits follow the winner
    a_r6_vector_level: assert property (@(posedge clk) disable iff (rst)
        (addr == A_VEC && win.hit) |-> (rdata[LVL_W-1:0] == win.lvl));

endmodule

// File: rtl/fixed_level_intc.sv
module fixed_level_intc
    import icu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tmr0_irq,
    input  logic        dma0_irq,
    input  logic        dma1_irq,
    input  logic        tmr1_irq,
    input  logic        tmr2_irq,
    input  logic        ack,
    input  logic [3:0]  addr,
    input  logic        wr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        irq
);

    slot_vec_t        src_set, req_q, isr_q, mask_q;
    pick_t            win;
    logic [LVL_W-1:0] plm, ctl_lvl;
    logic             wr_req, wr_isr, wr_mask, wr_ctl, wr_eoi;

    assign src_set = {tmr2_irq, tmr1_irq, dma1_irq, dma0_irq, 1'b0, tmr0_irq};

    icu_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr      (wr),
        .wdata   (wdata),
        .req_q   (req_q),
        .isr_q   (isr_q),
        .mask_q  (mask_q),
        .win     (win),
        .rdata   (rdata),
        .plm     (plm),
        .wr_req  (wr_req),
        .wr_isr  (wr_isr),
        .wr_mask (wr_mask),
        .wr_ctl  (wr_ctl),
        .ctl_lvl (ctl_lvl),
        .wr_eoi  (wr_eoi)
    );

    icu_state u_state (
        .clk     (clk),
        .rst     (rst),
        .src_set (src_set),
        .ack     (ack),
        .win     (win),
        .wr_req  (wr_req),
        .wr_isr  (wr_isr),
        .wr_mask (wr_mask),
        .wr_ctl  (wr_ctl),
        .ctl_lvl (ctl_lvl),
        .wr_eoi  (wr_eoi),
        .wbits   (wdata[SLOT_N-1:0]),
        .req_q   (req_q),
        .isr_q   (isr_q),
        .mask_q  (mask_q)
    );

    icu_arbiter u_arb (
        .clk    (clk),
        .rst    (rst),
        .req_q  (req_q),
        .isr_q  (isr_q),
        .mask_q (mask_q),
        .plm    (plm),
        .win    (win),
        .irq    (irq)
    );

endmodule

// File: tb/fixed_level_intc_tb.sv
`timescale 1ns/1ps
module fixed_level_intc_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tmr0_irq = 0, dma0_irq = 0, dma1_irq = 0, tmr1_irq = 0, tmr2_irq = 0;
    logic        ack = 0;
    logic [3:0]  addr = '0;
    logic        wr = 0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit running = 0;
    bit done = 0;

    // behavioural reference state
    bit m_req[6];
    bit m_isr[6];
    bit m_mask[6];
    int m_plm;
    int m_base;

    always #2 clk = ~clk;

    fixed_level_intc u_dut (
        .clk(clk), .rst(rst),
        .tmr0_irq(tmr0_irq), .dma0_irq(dma0_irq), .dma1_irq(dma1_irq),
        .tmr1_irq(tmr1_irq), .tmr2_irq(tmr2_irq),
        .ack(ack), .addr(addr), .wr(wr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    function automatic bit used(int l);
        return (l != 1);
    endfunction

    function automatic int ctl_level(int a);
        case (a)
            8:  return 0;
            9:  return 2;
            10: return 3;
            11: return 4;
            12: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic int m_win();
        int ceil_l;
        ceil_l = m_plm;
        for (int l = 0; l < 6; l++) if (m_isr[l] && l < ceil_l) ceil_l = l;
        for (int l = 0; l < 6; l++)
            if (used(l) && m_req[l] && !m_mask[l] && l < ceil_l) return l;
        return -1;
    endfunction

    function automatic int pack(bit v[6]);
        int r;
        r = 0;
        for (int l = 0; l < 6; l++) if (v[l]) r |= (1 << l);
        return r;
    endfunction

    function automatic int m_read(int a);
        int w;
        w = m_win();
        case (a)
            0: return m_base | ((w >= 0) ? w : 0);
            2: return pack(m_mask);
            3: return m_plm;
            4: return pack(m_isr);
            5: return pack(m_req);
            default: begin
                if (ctl_level(a) >= 0)
                    return (int'(m_mask[ctl_level(a)]) << 3) | ctl_level(a);
                return 0;
            end
        endcase
    endfunction

    always @(posedge clk) begin
        int w;
        int e;
        if (rst) begin
            for (int l = 0; l < 6; l++) begin
                m_req[l] = 0; m_isr[l] = 0; m_mask[l] = used(l);
            end
            m_plm = 7;
            m_base = 0;
        end else begin
            w = m_win();
            if (wr) begin
                case (int'(addr))
                    0: m_base = int'(wdata) & 16'hFFF8;
                    1: begin
                        e = int'(wdata[2:0]);
                        if (e < 6) m_isr[e] = 0;
                    end
                    2: for (int l = 0; l < 6; l++) m_mask[l] = used(l) && wdata[l];
                    3: m_plm = int'(wdata[2:0]);
                    4: for (int l = 0; l < 6; l++) m_isr[l] = used(l) && wdata[l];
                    5: m_req[0] = wdata[0];
                    default: if (ctl_level(int'(addr)) >= 0) m_mask[ctl_level(int'(addr))] = wdata[3];
                endcase
            end
            if (ack && w >= 0) begin
                m_req[w] = 0;
                m_isr[w] = 1;
            end
            if (tmr0_irq) m_req[0] = 1;
            if (dma0_irq) m_req[2] = 1;
            if (dma1_irq) m_req[3] = 1;
            if (tmr1_irq) m_req[4] = 1;
            if (tmr2_irq) m_req[5] = 1;
        end
    end

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // R4: interrupt line compared with the model on every clock
    always @(negedge clk) begin
        if (running && !rst) chk("R4 irq", int'(irq), int'(m_win() >= 0));
    end

    // one cycle of stimulus: write, acknowledge and peripheral pulses together
    task automatic cyc(bit w, int a, int d, bit [4:0] p, bit k);
        @(negedge clk);
        wr = w; addr = 4'(a); wdata = 16'(d); ack = k;
        {tmr2_irq, tmr1_irq, dma1_irq, dma0_irq, tmr0_irq} = p;
        @(negedge clk);
        wr = 0; ack = 0;
        {tmr2_irq, tmr1_irq, dma1_irq, dma0_irq, tmr0_irq} = '0;
    endtask

    task automatic wreg(int a, int d);
        cyc(1, a, d, 5'b0, 0);
    endtask

    task automatic rd(int a, string tag);
        @(negedge clk);
        addr = 4'(a);
        #1;
        chk(tag, int'(rdata), m_read(a));
    endtask

    task automatic rd_exp(int a, int exp, string tag);
        @(negedge clk);
        addr = 4'(a);
        #1;
        chk(tag, int'(rdata), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        running = 1;
        // R1
        rd_exp(5, 0, "R1 req after reset");
        rd_exp(4, 0, "R1 isr after reset");
        rd_exp(2, 16'h3D, "R1 mask after reset");
        rd_exp(3, 7, "R1 ceiling after reset");
        rd_exp(0, 0, "R1 vector after reset");
        chk("R1 irq after reset", int'(irq), 0);
        // R3: masked pulses still latch
        cyc(0, 0, 0, 5'b11111, 0);
        rd_exp(5, 16'h3D, "R3 req latched while masked");
        chk("R3 masked no irq", int'(irq), 0);
        wreg(2, 0);
        rd(0, "R6 vector base zero");
        wreg(0, 16'hABCD);
        rd_exp(0, 16'hABC8, "R6 vector base and level 0");
        // R5
        cyc(0, 0, 0, 5'b0, 1);
        rd_exp(5, 16'h3C, "R5 req cleared");
        rd_exp(4, 16'h01, "R5 isr set");
        chk("R5 level 0 blocks all", int'(irq), 0);
        cyc(0, 0, 0, 5'b0, 1);
        rd_exp(4, 16'h01, "R5 ack without irq ignored");
        rd_exp(5, 16'h3C, "R5 ack without irq req kept");
        // R7
        wreg(1, 0);
        rd_exp(4, 0, "R7 eoi level 0");
        rd_exp(0, 16'hABCA, "R6 vector level 2");
        // R4 ceiling
        wreg(3, 2);
        chk("R4 ceiling 2 blocks level 2", int'(irq), 0);
        wreg(3, 3);
        chk("R4 ceiling 3 passes level 2", int'(irq), 1);
        wreg(3, 7);
        // R9
        wreg(4, 16'h08);
        rd_exp(4, 16'h08, "R9 isr write");
        chk("R4 level 2 above service 3", int'(irq), 1);
        wreg(4, 16'h04);
        chk("R4 level 2 in service", int'(irq), 0);
        wreg(4, 0);
        // R10
        wreg(9, 16'h000F);
        rd_exp(2, 16'h04, "R10 ctl write seen in mask");
        rd_exp(9, 16'h000A, "R10 ctl read fixed level");
        wreg(2, 0);
        rd_exp(9, 16'h0002, "R10 mask write seen in ctl");
        rd(12, "R10 ctl level 5");
        // R8
        wreg(5, 16'hFFFF);
        rd_exp(5, 16'h3D, "R8 req only bit 0 set");
        wreg(5, 0);
        rd_exp(5, 16'h3C, "R8 req only bit 0 cleared");
        // R11
        wreg(6, 16'hFFFF);
        wreg(14, 16'hFFFF);
        rd_exp(6, 0, "R11 hole 6");
        rd_exp(13, 0, "R11 hole 13");
        rd(5, "R11 req untouched");
        rd(2, "R11 mask untouched");
        // R2
        wreg(2, 16'hFFFF);
        rd_exp(2, 16'h3D, "R2 mask unused bits zero");
        wreg(4, 16'hFFFF);
        rd_exp(4, 16'h3D, "R2 isr unused bits zero");
        wreg(4, 0);
        wreg(2, 0);
        // R12: re-raise during ack of dma0 (level 2)
        cyc(0, 0, 0, 5'b00010, 1);
        rd_exp(5, 16'h3C, "R12 pulse beats ack clear");
        rd_exp(4, 16'h04, "R12 ack set");
        // R12: ack sets level 2 while eoi names level 2
        wreg(4, 16'h08);
        cyc(1, 1, 2, 5'b0, 1);
        rd_exp(4, 16'h0C, "R12 ack beats eoi");
        // R7: unused codes
        cyc(1, 1, 1, 5'b0, 0);
        cyc(1, 1, 7, 5'b0, 0);
        rd_exp(4, 16'h0C, "R7 eoi codes 1 and 7 ignored");
        rd_exp(1, 0, "R7 eoi reads zero");
        rd(0, "R6 vector final");
        running = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule